// File: doc/BRIEF.md
# MSI doorbell interrupt controller

This block collects message-signalled interrupts for a host. An endpoint signals an interrupt with a single memory write to a doorbell offset. The write data is the vector number, and the block latches a pending flag for that vector. The block holds 256 vectors. Their pending flags and enable bits are grouped into banks of 32, and the host sees each bank as one 32-bit status word and one 32-bit enable word on a simple memory-mapped register bus.

One summary interrupt line goes to the host. It is high while at least one vector is both pending and enabled. Software reads the status words to find the active vectors and acknowledges a vector by writing a one to its status bit. Each doorbell write is one edge-type event and stays latched until it is acknowledged.

Inbound doorbell writes arrive on a valid/ready port. Ready is always high, so a write is taken in every cycle that valid is high and the port never back-pressures the sender. The host register bus uses plain write and read strobes, and read data returns one cycle after the read strobe.

Top module: `msi_doorbell_ctrl`

## Requirements
- R1: After reset, every pending flag and every enable bit is zero and `irq_o` is low. A read of any status or enable word returns 0.
- R2: An inbound write with address 0x7C and data n (n < 256) sets the pending flag of vector n. Vector n is bit n mod 32 of the status word at byte offset 0x80 + 4*(n/32). A doorbell for a vector that is already pending leaves it pending.
- R3: An inbound write with data of 256 or above changes no pending flag. An inbound write to any address other than 0x7C also changes no pending flag.
- R4: A host write to a status word clears each pending flag whose bit is 1 in the write data. Flags whose bit is 0 keep their value.
- R5: The enable words sit at byte offset 0xA0 + 4*k (k = 0..7) and use the same vector-to-bit mapping as the status words. A host write stores the data unchanged, a 1 enables the vector, and a read returns the stored value.
- R6: `irq_o` is the OR, over all vectors, of pending AND enabled. It is derived combinationally from the registered state, so it reflects a write in the cycle after that write.
- R7: A vector that becomes pending while disabled keeps its flag and does not raise `irq_o`. It raises `irq_o` as soon as its enable bit is written to 1.
- R8: When a doorbell and a status write that clears the same vector happen in the same cycle, the vector ends up pending.
- R9: The read data output is registered. It carries the addressed word in the cycle after `reg_rd_en` and is 0 in every other cycle. Reads of unmapped, misaligned or doorbell addresses return 0. Host writes to those addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ib_valid | input | 1 | Inbound memory write present |
| ib_ready | output | 1 | Always 1: inbound writes are never stalled |
| ib_addr | input | 8 | Inbound write byte offset |
| ib_data | input | 32 | Inbound write data (vector number) |
| reg_wr_en | input | 1 | Host register write strobe |
| reg_rd_en | input | 1 | Host register read strobe |
| reg_addr | input | 8 | Host register byte offset |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, valid the cycle after reg_rd_en |
| irq_o | output | 1 | Summary interrupt, high while any vector is pending and enabled |

## Verification
Directed doorbells on vectors 0, 31, 32 and 255 show that the vector decode places each vector at the right bank and bit, including the edges of a bank and of the whole array. Doorbells with out-of-range data and writes to the wrong inbound address separate a correct ignore from a truncated vector index. Partial write-one-to-clear patterns and a doorbell that collides with a clear of the same vector tell the clear and set priorities apart. Long runs of random doorbells, clears, enable writes and reads then check the summary line and every word readback against a bench model.

// File: rtl/msi_db_pkg.sv
package msi_db_pkg;

  // Which register array a host access selects
  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_STAT = 2'd1,
    REG_EN   = 2'd2
  } reg_sel_e;

  // Width of an index into n items, at least one bit
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/msi_db_decode.sv
// Turns an inbound memory write into a one-hot vector set mask.
module msi_db_decode #(
  parameter int ADDR_W  = 8,
  parameter int WORD_W  = 32,
  parameter int NUM_VEC = 256,
  parameter logic [ADDR_W-1:0] DB_OFS = 8'h7C
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ib_valid,
  input  logic [ADDR_W-1:0]  ib_addr,
  input  logic [WORD_W-1:0]  ib_data,
  output logic [NUM_VEC-1:0] set_vec
);
  localparam int VEC_W = msi_db_pkg::idx_width(NUM_VEC);

  logic fire;

  // Out-of-range vector numbers never fire
  assign fire = ib_valid && (ib_addr == DB_OFS) && (ib_data < WORD_W'(NUM_VEC));

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    assign set_vec[v] = fire && (ib_data[VEC_W-1:0] == VEC_W'(v));
  end

  AST_SET_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec)); // R2

  AST_BIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_data >= WORD_W'(NUM_VEC)) |-> (set_vec == '0)); // R3

  AST_WRONG_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_addr != DB_OFS) |-> (set_vec == '0)); // R3

endmodule

// File: rtl/msi_reg_decode.sv
// Maps a host byte offset onto a status or enable bank.
module msi_reg_decode #(
  parameter int ADDR_W   = 8,
  parameter int NUM_BANK = 8,
  parameter int STAT_OFS = 'h80,
  parameter int EN_OFS   = 'hA0
) (
  input  logic                                          [ADDR_W-1:0] addr,
  output msi_db_pkg::reg_sel_e                                       sel,
  output logic [msi_db_pkg::idx_width(NUM_BANK)-1:0]                 bank
);
  localparam int BANK_W  = msi_db_pkg::idx_width(NUM_BANK);
  localparam int STAT_WD = STAT_OFS / 4;
  localparam int EN_WD   = EN_OFS / 4;

  logic [ADDR_W-3:0] word;
  logic              aligned;
  int                word_i;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign word_i  = int'(word);

  always_comb begin
    sel  = msi_db_pkg::REG_NONE;
    bank = '0;
    if (aligned && word_i >= STAT_WD && word_i < STAT_WD + NUM_BANK) begin
      sel  = msi_db_pkg::REG_STAT;
      bank = BANK_W'(word_i - STAT_WD);
    end else if (aligned && word_i >= EN_WD && word_i < EN_WD + NUM_BANK) begin
      sel  = msi_db_pkg::REG_EN;
      bank = BANK_W'(word_i - EN_WD);
    end
  end

endmodule

// File: rtl/msi_vec_bank.sv
// One bank of pending flags and enable bits.
module msi_vec_bank #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] set_i,
  input  logic [WORD_W-1:0] clr_i,
  input  logic              en_we_i,
  input  logic [WORD_W-1:0] en_wdata_i,
  output logic [WORD_W-1:0] pend_o,
  output logic [WORD_W-1:0] en_o,
  output logic              irq_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_o <= '0;
      en_o   <= '0;
    end else begin
      // A set in the same cycle as a clear wins
      pend_o <= (pend_o & ~clr_i) | set_i;
      if (en_we_i) en_o <= en_wdata_i;
    end
  end

  assign irq_o = |(pend_o & en_o);

  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i))); // R2

  AST_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((pend_o & $past(clr_i & ~set_i)) == '0)); // R4

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0 && clr_i == '0) |=> $stable(pend_o)); // R4

  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i & clr_i) != '0) |=> ((pend_o & $past(set_i & clr_i)) == $past(set_i & clr_i))); // R8

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we_i |=> $stable(en_o)); // R5

endmodule

// File: rtl/msi_doorbell_ctrl.sv
// Doorbell-driven interrupt controller with banked pending/enable words.
module msi_doorbell_ctrl #(
  parameter int ADDR_W   = 8,
  parameter int WORD_W   = 32,
  parameter int NUM_VEC  = 256,
  parameter logic [ADDR_W-1:0] DB_OFS = 8'h7C,
  parameter int STAT_OFS = 'h80,
  parameter int EN_OFS   = 'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ib_valid,
  output logic              ib_ready,
  input  logic [ADDR_W-1:0] ib_addr,
  input  logic [WORD_W-1:0] ib_data,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq_o
);
  import msi_db_pkg::*;

  localparam int NUM_BANK = NUM_VEC / WORD_W;
  localparam int BANK_W   = idx_width(NUM_BANK);

  logic [NUM_VEC-1:0]  set_vec;
  reg_sel_e            sel;
  logic [BANK_W-1:0]   bank;
  logic [WORD_W-1:0]   pend_w [NUM_BANK];
  logic [WORD_W-1:0]   en_w   [NUM_BANK];
  logic [NUM_BANK-1:0] bank_irq;
  logic                stat_wr;
  logic                en_wr;

  assign ib_ready = 1'b1;

  msi_db_decode #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .NUM_VEC(NUM_VEC),
    .DB_OFS (DB_OFS)
  ) i_db_decode (
    .clk     (clk),
    .rst_n   (rst_n),
    .ib_valid(ib_valid),
    .ib_addr (ib_addr),
    .ib_data (ib_data),
    .set_vec (set_vec)
  );

  msi_reg_decode #(
    .ADDR_W  (ADDR_W),
    .NUM_BANK(NUM_BANK),
    .STAT_OFS(STAT_OFS),
    .EN_OFS  (EN_OFS)
  ) i_reg_decode (
    .addr(reg_addr),
    .sel (sel),
    .bank(bank)
  );

  assign stat_wr = reg_wr_en && (sel == REG_STAT);
  assign en_wr   = reg_wr_en && (sel == REG_EN);

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    logic hit;
    assign hit = (bank == BANK_W'(b));

    msi_vec_bank #(
      .WORD_W(WORD_W)
    ) i_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (set_vec[b*WORD_W +: WORD_W]),
      .clr_i     ((stat_wr && hit) ? reg_wdata : '0),
      .en_we_i   (en_wr && hit),
      .en_wdata_i(reg_wdata),
      .pend_o    (pend_w[b]),
      .en_o      (en_w[b]),
      .irq_o     (bank_irq[b])
    );
  end

  assign irq_o = |bank_irq;

  // Registered read port, zero outside a read response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd_en) begin
      case (sel)
        REG_STAT: reg_rdata <= pend_w[bank];
        REG_EN:   reg_rdata <= en_w[bank];
        default:  reg_rdata <= '0;
      endcase
    end else begin
      reg_rdata <= '0;
    end
  end

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> (reg_rdata == '0)); // R9

  AST_IRQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == '0 && !stat_wr && !en_wr) |=> $stable(irq_o)); // R6

  AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(set_vec) != '0 || $past(en_wr))); // R7

endmodule

// File: tb/test_msi_doorbell_ctrl.sv
module test_msi_doorbell_ctrl;
  localparam int NB = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ib_valid = 1'b0;
  logic        ib_ready;
  logic [7:0]  ib_addr = '0;
  logic [31:0] ib_data = '0;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;

  logic [31:0] pend_m [NB];
  logic [31:0] en_m   [NB];

  always #5 clk = ~clk;

  msi_doorbell_ctrl i_msi_doorbell_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ib_valid(ib_valid), .ib_ready(ib_ready), .ib_addr(ib_addr), .ib_data(ib_data),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  function automatic logic exp_irq();
    logic r = 1'b0;
    for (int k = 0; k < NB; k++) r |= |(pend_m[k] & en_m[k]);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic ring(input logic [7:0] a, input logic [31:0] d);
    ib_valid = 1'b1; ib_addr = a; ib_data = d;
    @(negedge clk);
    ib_valid = 1'b0;
    if (a == 8'h7C && d < 256) pend_m[d/32][d%32] = 1'b1;
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    if (a >= 8'h80 && a < 8'hA0 && a[1:0] == 0) pend_m[(a-8'h80)/4] &= ~d;
    if (a >= 8'hA0 && a < 8'hC0 && a[1:0] == 0) en_m[(a-8'hA0)/4] = d;
  endtask

  task automatic both(input logic [31:0] v, input int k, input logic [31:0] d);
    ib_valid = 1'b1; ib_addr = 8'h7C; ib_data = v;
    reg_wr_en = 1'b1; reg_addr = 8'(8'h80 + 4*k); reg_wdata = d;
    @(negedge clk);
    ib_valid = 1'b0; reg_wr_en = 1'b0;
    pend_m[k] &= ~d;
    if (v < 256) pend_m[v/32][v%32] = 1'b1;
  endtask

  task automatic host_rd(input logic [7:0] a, output logic [31:0] d);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic chk_all(input string tag);
    logic [31:0] d;
    for (int k = 0; k < NB; k++) begin
      host_rd(8'(8'h80 + 4*k), d); chk({tag, " status"}, d, pend_m[k]);
      host_rd(8'(8'hA0 + 4*k), d); chk({tag, " enable"}, d, en_m[k]);
    end
  endtask

  task automatic chk_irq(input string tag);
    chk(tag, {31'd0, irq_o}, {31'd0, exp_irq()});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4711));
    for (int k = 0; k < NB; k++) begin pend_m[k] = '0; en_m[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);
    chk("R1 ready", {31'd0, ib_ready}, 32'd1);
    chk_all("R1");

    // R2 vector placement at bank and array edges
    ring(8'h7C, 0);   ring(8'h7C, 31);
    ring(8'h7C, 32);  ring(8'h7C, 255);
    ring(8'h7C, 255);
    host_rd(8'h80, d); chk("R2 word0", d, 32'h8000_0001);
    host_rd(8'h84, d); chk("R2 word1", d, 32'h0000_0001);
    host_rd(8'h9C, d); chk("R2 word7", d, 32'h8000_0000);
    chk("R7 masked no irq", {31'd0, irq_o}, 32'd0);

    // R3 ignored doorbells
    ring(8'h7C, 256); ring(8'h7C, 32'h0000_1005);
    ring(8'h80, 5);   ring(8'h7D, 6);
    chk_all("R3");

    // R4 partial write-one-to-clear
    host_wr(8'h80, 32'h0000_0001);
    host_rd(8'h80, d); chk("R4 partial clear", d, 32'h8000_0000);
    host_wr(8'h9C, 32'h7FFF_FFFF);
    host_rd(8'h9C, d); chk("R4 zero bits kept", d, 32'h8000_0000);

    // R5 enable readback
    host_wr(8'hA4, 32'hA5A5_0000);
    host_rd(8'hA4, d); chk("R5 enable readback", d, 32'hA5A5_0000);
    chk("R6 no overlap", {31'd0, irq_o}, 32'd0);

    // R7 masked pending raises irq when enabled
    host_wr(8'hBC, 32'h8000_0000);
    chk("R7 irq on enable", {31'd0, irq_o}, 32'd1);
    host_wr(8'h9C, 32'h8000_0000);
    chk("R6 irq drops on ack", {31'd0, irq_o}, 32'd0);

    // R8 same-cycle set and clear
    both(32'd40, 1, 32'h0000_0100);
    host_rd(8'h84, d); chk("R8 doorbell wins", d, 32'h0000_0101);

    // R9 unmapped and doorbell offsets
    host_wr(8'h40, 32'hFFFF_FFFF); host_wr(8'h7C, 32'd3); host_wr(8'hA1, 32'hFFFF_FFFF);
    host_rd(8'h40, d); chk("R9 unmapped read", d, 0);
    host_rd(8'h7C, d); chk("R9 doorbell read", d, 0);
    chk("R9 idle rdata", reg_rdata, 0);
    chk_all("R9");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      int op = $urandom % 5;
      int k = $urandom % NB;
      case (op)
        0: ring(8'h7C, $urandom % 300);
        1: host_wr(8'(8'h80 + 4*k), $urandom & $urandom);
        2: host_wr(8'(8'hA0 + 4*k), $urandom & $urandom & $urandom);
        3: begin
          host_rd(8'(8'h80 + 4*k), d); chk("R2 random status", d, pend_m[k]);
        end
        default: both($urandom % 256, k, $urandom);
      endcase
      chk_irq("R6 random irq");
    end
    chk_all("R5 final");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule